// File: doc/BRIEF.md
# Event log ring controller

This block keeps a circular log of fixed-size event records in system memory and holds the small register bank that software uses to run it. The bank has five registers: control, status, ring base plus size, head, and tail. An internal event source offers one 16-byte record at a time. For each record the block computes where the tail would move next and checks that position against the head. It then does one of three things: drops the record, writes it to memory through a simple request/done handshake, or reports an overflow.

Software sets the ring's base and size and consumes records by moving the head. It acknowledges flags in the status register by writing ones to them. After a successful write the tail advances. When the interrupt enable is set, the block also raises a status flag and gives a one-cycle interrupt request. Pointers are byte offsets into the ring and are always multiples of 16.

Top module: `evlog_ring`

## Requirements
- R1: Every register write keeps read-only bits, clears write-one-to-clear bits that are written with 1, and loads the value written into all other bits. Register addresses are: 0 control, 1 status, 2 base, 3 head, 4 tail. Other addresses read 0. Control bit 0 is the global enable, bit 1 the logging enable and bit 2 the interrupt enable; its other bits read 0.
- R2: Status bits are: 0 overflow, 1 event interrupt, 2 completion interrupt (never set here, so it reads 0), 3 logging active (control bit 0 AND control bit 1, read-only), 4 command running (reads 0). Bits 0 to 2 are write-one-to-clear. If a hardware set and a software clear hit the same cycle, the set wins.
- R3: `ev_ready` is high exactly when no memory write is pending, and a record is taken when `ev_valid` and `ev_ready` are both high. A record taken while logging is inactive, or while the overflow bit is set, is dropped: no memory write, no pointer change, no status change and no interrupt.
- R4: The next tail is (tail + 16) modulo (16 × 2^size), where size is base bits [3:0]. The write goes to {base[31:4], 4'b0} + tail, and the record appears on `mem_wdata`.
- R5: The ring is full when the next tail equals the head as it was before any head write in the same cycle. A full ring writes nothing and leaves the tail where it is. With the interrupt enable set, it also sets the overflow bit and pulses `irq`. Without the enable, nothing changes.
- R6: `mem_req` rises in the cycle after a record is taken. It holds, with `mem_addr` and `mem_wdata` stable, up to and including the cycle in which `mem_done` is high. At that edge the tail takes the next value. If the interrupt enable is set, the event interrupt bit is set and `irq` is high for the following cycle.
- R7: `mem_err` together with `mem_done` gives a one-cycle `dbg_err` pulse. The tail still advances.
- R8: A base write loads the base register and sets head and tail to 0. The whole write is ignored (base, head and tail unchanged) while the event interrupt bit is set.
- R9: Head bits [31:4] are writable and its bits [3:0] read 0. The tail is read-only, so writes to it have no effect.
- R10: After reset all registers read 0, `ev_ready` is 1, and `mem_req`, `irq` and `dbg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| ev_valid | input | 1 | Event record offered |
| ev_data | input | 128 | Event record |
| ev_ready | output | 1 | Block idle; a record can be taken |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 128 | Record being written |
| mem_done | input | 1 | Memory write finished |
| mem_err | input | 1 | Memory write failed (qualified by mem_done) |
| irq | output | 1 | Interrupt request pulse |
| dbg_err | output | 1 | Failed-write debug pulse |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a write completes and sets the event interrupt bit on the same edge that software writes 1 to clear that bit. In the second, software moves the head on the same edge that a record is taken and checked for a full ring. The bench provokes the first on purpose: it waits for the cycle in which `mem_done` is driven high and issues the status clear in that cycle. A long random phase then collides register writes of every kind with takes, completions and errors. In both cases a behavioural model rules that the hardware set wins and that the full check uses the old head, and the model is compared with the design on every clock.

// File: rtl/evlog_ring.sv
module evlog_ring #(
  parameter int AW     = 32,
  parameter int SZW    = 4,
  parameter int ENT_LG = 4,
  parameter int RECW   = 8 << ENT_LG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  input  logic            ev_valid,
  input  logic [RECW-1:0] ev_data,
  output logic            ev_ready,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [RECW-1:0] mem_wdata,
  input  logic            mem_done,
  input  logic            mem_err,
  output logic            irq,
  output logic            dbg_err
);

  localparam logic [AW-1:0] ENT_BYTES = AW'(1 << ENT_LG);
  localparam logic [AW-1:0] LOW_MASK  = ENT_BYTES - 1'b1;
  localparam logic [AW-1:0] FLAG_BITS = AW'(7);
  localparam logic [AW-1:0] CTRL_RO   = ~FLAG_BITS;
  localparam logic [AW-1:0] STAT_RO   = ~FLAG_BITS;
  localparam logic [AW-1:0] STAT_W1C  = FLAG_BITS;
  localparam logic [AW-1:0] NONE      = '0;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_BASE = 3'd2;
  localparam logic [2:0] A_HEAD = 3'd3;
  localparam logic [2:0] A_TAIL = 3'd4;

  function automatic logic [AW-1:0] wmerge(input logic [AW-1:0] old_v, new_v, ro, w1c);
    return ((old_v & (ro | w1c)) | (new_v & ~ro)) & ~(new_v & w1c);
  endfunction

  logic [2:0]      ctrl_q;
  logic            ovf_q, evint_q, busy_q, irq_q, err_q;
  logic [AW-1:0]   base_q, head_q, tail_q, nxt_q, addr_q;
  logic [RECW-1:0] rec_q;

  wire log_on = ctrl_q[0] & ctrl_q[1];
  wire ien    = ctrl_q[2];

  wire [SZW-1:0] sz        = base_q[SZW-1:0];
  wire [AW-1:0]  ring_mask = (AW'(1) << (ENT_LG + int'(sz))) - 1'b1;
  wire [AW-1:0]  base_addr = base_q & ~LOW_MASK;
  wire [AW-1:0]  next_tail = (tail_q + ENT_BYTES) & ring_mask;
  wire           full      = (next_tail == head_q);

  wire take   = ev_valid & ~busy_q & log_on & ~ovf_q;
  wire start  = take & ~full;
  wire ovfl   = take & full & ien;
  wire finish = busy_q & mem_done;

  wire [AW-1:0] ctrl_rd = AW'(ctrl_q);
  wire [AW-1:0] stat_rd = AW'({1'b0, log_on, 1'b0, evint_q, ovf_q});

  wire [AW-1:0] ctrl_new = wmerge(ctrl_rd, reg_wdata, CTRL_RO, NONE);
  wire [AW-1:0] stat_new = wmerge(stat_rd, reg_wdata, STAT_RO, STAT_W1C);
  wire [AW-1:0] head_new = wmerge(head_q, reg_wdata, LOW_MASK, NONE);

  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wr_stat = reg_we && reg_addr == A_STAT;
  wire wr_base = reg_we && reg_addr == A_BASE && !evint_q;
  wire wr_head = reg_we && reg_addr == A_HEAD;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_rd;
      A_STAT:  reg_rdata = stat_rd;
      A_BASE:  reg_rdata = base_q;
      A_HEAD:  reg_rdata = head_q;
      A_TAIL:  reg_rdata = tail_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ovf_q   <= 1'b0;
      evint_q <= 1'b0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      base_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      nxt_q   <= '0;
      addr_q  <= '0;
      rec_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
      if (wr_ctrl) ctrl_q <= ctrl_new[2:0];
      if (wr_stat) begin
        ovf_q   <= stat_new[0];
        evint_q <= stat_new[1];
      end
      if (wr_base) begin
        base_q <= reg_wdata;
        head_q <= '0;
        tail_q <= '0;
      end
      if (wr_head) head_q <= head_new;
      if (ovfl) begin
        ovf_q <= 1'b1;
        irq_q <= 1'b1;
      end
      if (start) begin
        busy_q <= 1'b1;
        nxt_q  <= next_tail;
        addr_q <= base_addr + tail_q;
        rec_q  <= ev_data;
      end
      if (finish) begin
        busy_q <= 1'b0;
        tail_q <= nxt_q;
        err_q  <= mem_err;
        if (ien) begin
          evint_q <= 1'b1;
          irq_q   <= 1'b1;
        end
      end
    end
  end

  assign ev_ready  = ~busy_q;
  assign mem_req   = busy_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = rec_q;
  assign irq       = irq_q;
  assign dbg_err   = err_q;

endmodule

// File: rtl/evlog_ring_chk.sv
module evlog_ring_chk #(
  parameter int AW   = 32,
  parameter int RECW = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic            ev_valid,
  input logic            ev_ready,
  input logic            mem_req,
  input logic [AW-1:0]   mem_addr,
  input logic [RECW-1:0] mem_wdata,
  input logic            mem_done,
  input logic            mem_err,
  input logic            irq,
  input logic            dbg_err,
  input logic            ien,
  input logic            ovf,
  input logic            evint,
  input logic [AW-1:0]   base,
  input logic [AW-1:0]   tail
);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  a_r6_tail_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_done) && !(reg_we && reg_addr == 3'd2 && !evint) |=> $stable(tail));

  a_r5_ovf_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(ien));

  a_r6_irq_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ien));

  a_r3_drop_when_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && ev_valid && ev_ready |=> !mem_req);

  a_r8_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 3'd2 && evint |=> $stable(base));

  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_err |-> $past(mem_req && mem_done && mem_err));

endmodule

bind evlog_ring evlog_ring_chk #(.AW(AW), .RECW(RECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_done(mem_done),
  .mem_err(mem_err), .irq(irq), .dbg_err(dbg_err), .ien(ctrl_q[2]),
  .ovf(ovf_q), .evint(evint_q), .base(base_q), .tail(tail_q)
);

// File: tb/evlog_ring_tb.sv
`timescale 1ns/1ps
module evlog_ring_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         ev_valid = 1'b0;
  logic [127:0] ev_data = '0;
  logic         ev_ready, mem_req, irq, dbg_err;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_done = 1'b0, mem_err = 1'b0;

  evlog_ring u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_data(ev_data), .ev_ready(ev_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_done(mem_done),
    .mem_err(mem_err), .irq(irq), .dbg_err(dbg_err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lat = 1, wcnt = 0;
  bit err_pick = 0;

  // behavioural reference
  logic [2:0]   m_ctrl = '0;
  bit           m_ovf = 0, m_evint = 0, m_busy = 0, m_irq = 0, m_err = 0;
  logic [31:0]  m_base = '0, m_head = '0, m_tail = '0, m_nxt = '0, m_addr = '0;
  logic [127:0] m_rec = '0;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {29'd0, m_ctrl};
      3'd1: return {27'd0, 1'b0, m_ctrl[0] & m_ctrl[1], 1'b0, m_evint, m_ovf};
      3'd2: return m_base;
      3'd3: return m_head;
      3'd4: return m_tail;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_ovf = 0; m_evint = 0; m_busy = 0; m_irq = 0; m_err = 0;
      m_base = '0; m_head = '0; m_tail = '0; m_nxt = '0; m_addr = '0; m_rec = '0;
    end else begin
      bit on, en, o_ovf, o_evint, o_busy;
      longint ring, nt;
      logic [31:0] o_head, o_tail, o_base;
      on = m_ctrl[0] && m_ctrl[1]; en = m_ctrl[2];
      o_ovf = m_ovf; o_evint = m_evint; o_busy = m_busy;
      o_head = m_head; o_tail = m_tail; o_base = m_base;
      m_irq = 0; m_err = 0;
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_ctrl = reg_wdata[2:0];
          3'd1: begin
            if (reg_wdata[0]) m_ovf = 0;
            if (reg_wdata[1]) m_evint = 0;
          end
          3'd2: if (!o_evint) begin m_base = reg_wdata; m_head = 0; m_tail = 0; end
          3'd3: m_head = {reg_wdata[31:4], 4'd0};
          default: ;
        endcase
      end
      if (!o_busy && ev_valid && on && !o_ovf) begin
        ring = 64'd16 << o_base[3:0];
        nt = (longint'(o_tail) + 16) % ring;
        if (nt == longint'(o_head)) begin
          if (en) begin m_ovf = 1; m_irq = 1; end
        end else begin
          m_busy = 1; m_nxt = nt[31:0];
          m_addr = {o_base[31:4], 4'd0} + o_tail; m_rec = ev_data;
        end
      end
      if (o_busy && mem_done) begin
        m_busy = 0; m_tail = m_nxt; m_err = mem_err;
        if (en) begin m_evint = 1; m_irq = 1; end
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3 ev_ready", 128'(ev_ready), 128'(!m_busy));
    chk("R6 mem_req", 128'(mem_req), 128'(m_busy));
    if (m_busy) begin
      chk("R4 mem_addr", 128'(mem_addr), 128'(m_addr));
      chk("R4 mem_wdata", mem_wdata, m_rec);
    end
    chk("R6 irq", 128'(irq), 128'(m_irq));
    chk("R7 dbg_err", 128'(dbg_err), 128'(m_err));
    chk("R1 reg_rdata", 128'(reg_rdata), 128'(m_read(reg_addr)));
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) compare_all();
    if (mem_req) begin
      mem_done = (wcnt >= lat);
      mem_err  = err_pick;
      wcnt++;
    end else begin
      mem_done = 0; mem_err = 0; wcnt = 0;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #0.5;
    chk(tag, 128'(reg_rdata), 128'(exp));
  endtask

  task automatic send(input logic [127:0] d);
    while (!ev_ready) step();
    ev_valid = 1; ev_data = d;
    step();
    ev_valid = 0;
    step();
    while (mem_req) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ev_ready", 128'(ev_ready), 128'(1));
    chk("R10 mem_req", 128'(mem_req), 128'(0));
    chk("R10 irq", 128'(irq), 128'(0));
    expect_reg(3'd0, 32'h0, "R10 ctrl");
    expect_reg(3'd1, 32'h0, "R10 status");
    expect_reg(3'd4, 32'h0, "R10 tail");

    wr(3'd2, 32'h1000_0002);                 // 4 entries, 64-byte ring
    wr(3'd0, 32'hFFFF_FFFF);
    expect_reg(3'd0, 32'h7, "R1 ctrl rw bits");
    expect_reg(3'd1, 32'h8, "R2 running bit");

    lat = 2;
    for (int i = 0; i < 3; i++) send({4{32'hA5A5_0000 + i}});
    expect_reg(3'd4, 32'h30, "R6 tail after three writes");
    expect_reg(3'd1, 32'hA, "R6 event interrupt bit");

    send({4{32'h0BAD_F00D}});                // next 0 == head 0
    expect_reg(3'd4, 32'h30, "R5 tail held when full");
    expect_reg(3'd1, 32'hB, "R5 overflow set");

    send({4{32'h1111_1111}});                // dropped under overflow
    expect_reg(3'd4, 32'h30, "R3 drop under overflow");

    wr(3'd2, 32'h2000_0003);
    expect_reg(3'd2, 32'h1000_0002, "R8 base locked by event interrupt");

    wr(3'd1, 32'h3);
    expect_reg(3'd1, 32'h8, "R2 w1c clear");
    wr(3'd1, 32'h18);
    expect_reg(3'd1, 32'h8, "R1 read-only status bits");

    wr(3'd3, 32'h35);
    expect_reg(3'd3, 32'h30, "R9 head low bits zero");
    wr(3'd4, 32'h50);
    expect_reg(3'd4, 32'h30, "R9 tail read-only");

    err_pick = 1;
    send({4{32'hDEAD_BEEF}});                // write at base+0x30
    err_pick = 0;
    expect_reg(3'd4, 32'h0, "R7 tail advances after error");

    wr(3'd1, 32'h2);
    wr(3'd2, 32'h2000_0003);                 // 8 entries
    expect_reg(3'd2, 32'h2000_0003, "R8 base loaded");
    expect_reg(3'd3, 32'h0, "R8 head reset");
    expect_reg(3'd4, 32'h0, "R8 tail reset");

    wr(3'd0, 32'h3);
    lat = 0;
    for (int i = 0; i < 8; i++) send({4{32'h7700_0000 + i}});
    expect_reg(3'd4, 32'h70, "R5 full without enable keeps tail");
    expect_reg(3'd1, 32'h8, "R5 no overflow without enable");

    wr(3'd0, 32'h7);
    wr(3'd3, 32'h10);
    lat = 3;
    while (!ev_ready) step();
    ev_valid = 1; ev_data = {4{32'hC0DE_C0DE}};
    step();
    ev_valid = 0;
    while (!mem_done) step();
    reg_we = 1; reg_addr = 3'd1; reg_wdata = 32'h2;   // clear collides with set
    step();
    reg_we = 0;
    expect_reg(3'd1, 32'hA, "R2 hardware set wins over clear");
    expect_reg(3'd4, 32'h0, "R4 tail wraps to zero");

    wr(3'd1, 32'h2);
    wr(3'd0, 32'h4);
    send({4{32'h5555_5555}});
    expect_reg(3'd4, 32'h0, "R3 drop while logging off");
    expect_reg(3'd1, 32'h0, "R3 status untouched while off");

    for (int i = 0; i < 3000; i++) begin
      reg_we    = ($urandom % 6) == 0;
      reg_addr  = 3'($urandom % 8);
      reg_wdata = $urandom;
      if (reg_addr == 3'd0 && ($urandom % 4) != 0) reg_wdata[2:0] = 3'b111;
      if (reg_addr == 3'd2) reg_wdata[3:0] = 4'($urandom % 4);
      ev_valid  = $urandom % 2;
      ev_data   = {$urandom, $urandom, $urandom, $urandom};
      err_pick  = ($urandom % 4) == 0;
      if (!mem_req) lat = $urandom % 3;
      step();
    end
    reg_we = 0; ev_valid = 0;
    repeat (8) step();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule